// File: doc/BRIEF.md
# Pseudo-random test pattern generator and checker

This block puts a known pseudo-random bit sequence on the transmit path of a line interface and checks for the same sequence in a received bit stream. A 2-bit select chooses what leaves on the transmit side: the user's data, a constant one, a constant zero or the pattern. The pattern is either a 15-stage maximal-length sequence or a 20-stage sequence whose zero runs are limited to 14 bits. A single control bit complements the pattern on both the transmit and the receive side.

On the receive side the checker locks onto the incoming sequence by itself. While it is out of lock it copies received bits into its history register. Once it is locked it predicts each bit on its own and compares the prediction with the received bit. Lock is judged once per block of 64 consecutive valid bits. The mismatches seen while locked feed a saturating counter, which software reads through a snapshot-and-clear strobe. A sticky status bit records changes of the lock flag and drives an interrupt output.

Top module: `prbs_gen_mon`

## Requirements
- R1: Transmit select `patt_sel`: 00 sends `tx_data_in` when `zero_sel`=0 and a constant 0 when `zero_sel`=1; 01 sends a constant 1; 10 sends the pattern; 11 sends `tx_data_in`.
- R2: With `mode_qrss`=0 the raw sequence obeys x[n] = x[n-15] XOR x[n-14]. Parameter SEED gives the history, with bit 0 as x[n-1]. The sequence advances one bit on each cycle that has `tx_en`=1 and `patt_sel`=10, and `tx_data_out` shows x[n].
- R3: With `mode_qrss`=1 the raw sequence obeys x[n] = x[n-20] XOR x[n-17]. The bit sent is 1 when x[n]=1 or when x[n+1] to x[n+14] are all 0, so no more than 14 consecutive zeros are sent.
- R4: `invert`=1 complements the pattern bits that are sent and the pattern bits that the checker expects.
- R5: Lock is judged over consecutive blocks of 64 valid received bits, counted from reset. At the end of a block, `sync` becomes 1 if the block held at most 6 mismatches and 0 if it held more. `sync` changes at no other time.
- R6: While out of lock the checker loads received bits into its history register. While locked it ignores them and free-runs, so up to 6 errors in a block keep it locked and leave later predictions correct.
- R7: `err_count` adds one for each mismatch on a valid bit received while `sync`=1, adds nothing while `sync`=0, and holds at all ones (ERR_W bits, default 16).
- R8: A pulse on `err_latch` copies `err_count` into `err_snap` and restarts the counter at 0, or at 1 if a counted mismatch arrives in the same cycle.
- R9: `irq_status` becomes 1 on a 0-to-1 change of `sync`. It also becomes 1 on a 1-to-0 change when `irq_any_edge`=1. It stays 1 until `irq_clr`, and a new change wins over a clear in the same cycle. `irq` = `irq_status` AND `irq_en`.
- R10: After reset, `sync`, `err_count`, `err_snap` and `irq_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_qrss | input | 1 | 0: 15-stage pattern, 1: 20-stage zero-limited pattern |
| patt_sel | input | 2 | Transmit source select |
| zero_sel | input | 1 | Turns code 00 into constant zero |
| invert | input | 1 | Complement the pattern on both paths |
| tx_en | input | 1 | Transmit bit strobe, advances the generator |
| tx_data_in | input | 1 | User transmit data |
| tx_data_out | output | 1 | Transmitted bit |
| rx_valid | input | 1 | Received bit strobe |
| rx_data | input | 1 | Received bit |
| sync | output | 1 | Checker lock flag |
| err_latch | input | 1 | Snapshot-and-clear strobe for the error counter |
| err_count | output | ERR_W | Live saturating error count |
| err_snap | output | ERR_W | Last snapshot |
| irq_any_edge | input | 1 | 1: capture both edges of `sync` |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears `irq_status` |
| irq_status | output | 1 | Sticky change flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted generator history shows up on `tx_data_out` in the same cycle, as a bit that breaks the recurrence. A corrupted checker history is only visible through its effects. Because the checker free-runs while locked, it produces a run of mismatches that pushes the block over 6 errors and clears `sync` at the next 64-bit boundary, up to 64 valid bits later. A wrong block counter moves the boundaries, so `sync` changes at a bit index that is not a multiple of 64. A counter or snapshot fault appears at once on `err_count` and `err_snap`.

// File: rtl/prbs_gen_mon.sv
module prbs_gen_mon #(
  parameter int          ERR_W     = 16,
  parameter int          WIN_LEN   = 64,
  parameter int          WIN_LIMIT = 6,
  parameter int          LOOK      = 14,
  parameter logic [19:0] SEED      = 20'hFFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_qrss,
  input  logic [1:0]       patt_sel,
  input  logic             zero_sel,
  input  logic             invert,
  input  logic             tx_en,
  input  logic             tx_data_in,
  output logic             tx_data_out,
  input  logic             rx_valid,
  input  logic             rx_data,
  output logic             sync,
  input  logic             err_latch,
  output logic [ERR_W-1:0] err_count,
  output logic [ERR_W-1:0] err_snap,
  input  logic             irq_any_edge,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             irq_status,
  output logic             irq
);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int WE_W  = $clog2(WIN_LIMIT + 2);

  function automatic logic [LOOK:0] future(input logic [19:0] h, input logic q);
    logic [LOOK:0] f;
    for (int j = 0; j <= LOOK; j++) f[j] = h[19-j] ^ h[16-j];
    if (!q) f = {{LOOK{1'b0}}, h[14] ^ h[13]};
    return f;
  endfunction

  function automatic logic line_bit(input logic [LOOK:0] f, input logic q);
    return f[0] | (q && (f[LOOK:1] == '0));
  endfunction

  logic [19:0]     gen, mon;
  logic [LOOK:0]   gen_f, mon_f;
  logic            gen_zero, pat_bit;
  logic            rx_bit, exp_bit, mis;
  logic [WIN_W-1:0] wcnt;
  logic [WE_W-1:0]  werr;
  logic [WE_W:0]    wsum;
  logic            win_end, sync_nxt, cnt_inc, capture;

  assign gen_f    = future(gen, mode_qrss);
  assign gen_zero = mode_qrss ? (gen == '0) : (gen[14:0] == '0);
  assign pat_bit  = line_bit(gen_f, mode_qrss) ^ invert;

  assign tx_data_out = (patt_sel == 2'b01) ? 1'b1 :
                       (patt_sel == 2'b10) ? pat_bit :
                       (patt_sel == 2'b00 && zero_sel) ? 1'b0 : tx_data_in;

  always_ff @(posedge clk) begin
    if (!rst_n || gen_zero)
      gen <= SEED;
    else if (tx_en && patt_sel == 2'b10)
      gen <= {gen[18:0], gen_f[0]};
  end

  assign mon_f    = future(mon, mode_qrss);
  assign exp_bit  = line_bit(mon_f, mode_qrss);
  assign rx_bit   = rx_data ^ invert;
  assign mis      = rx_bit != exp_bit;
  assign wsum     = {1'b0, werr} + (WE_W+1)'(mis);
  assign win_end  = rx_valid && (wcnt == WIN_W'(WIN_LEN - 1));
  assign sync_nxt = win_end ? (wsum <= (WE_W+1)'(WIN_LIMIT)) : sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon  <= '0;
      wcnt <= '0;
      werr <= '0;
      sync <= 1'b0;
    end else if (rx_valid) begin
      mon  <= sync ? {mon[18:0], mon_f[0]} : {mon[18:0], rx_bit};
      wcnt <= wcnt + 1'b1;
      if (win_end)
        werr <= '0;
      else if (wsum > (WE_W+1)'(WIN_LIMIT))
        werr <= WE_W'(WIN_LIMIT + 1);
      else
        werr <= wsum[WE_W-1:0];
      sync <= sync_nxt;
    end
  end

  assign cnt_inc = rx_valid && sync && mis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_count <= '0;
      err_snap  <= '0;
    end else if (err_latch) begin
      err_snap  <= err_count;
      err_count <= ERR_W'(cnt_inc);
    end else if (cnt_inc && err_count != '1) begin
      err_count <= err_count + 1'b1;
    end
  end

  assign capture = (sync_nxt != sync) && (irq_any_edge || sync_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_status <= 1'b0;
    else if (capture) irq_status <= 1'b1;
    else if (irq_clr) irq_status <= 1'b0;
  end

  assign irq = irq_status & irq_en;
endmodule

// File: rtl/prbs_gen_mon_chk.sv
module prbs_gen_mon_chk #(
  parameter int ERR_W   = 16,
  parameter int WIN_LEN = 64,
  parameter int LOOK    = 14
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mode_qrss,
  input logic [1:0]                 patt_sel,
  input logic                       zero_sel,
  input logic                       invert,
  input logic                       tx_en,
  input logic                       tx_data_out,
  input logic                       rx_valid,
  input logic                       sync,
  input logic [$clog2(WIN_LEN)-1:0] wcnt,
  input logic [19:0]                gen,
  input logic                       err_latch,
  input logic [ERR_W-1:0]           err_count,
  input logic                       irq_any_edge,
  input logic                       irq_status
);
  logic [4:0] zrun;

  always_ff @(posedge clk) begin
    if (!rst_n || !(mode_qrss && !invert && patt_sel == 2'b10)) zrun <= '0;
    else if (tx_en) zrun <= tx_data_out ? 5'd0 : zrun + 5'd1;
  end

  a_r1_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    patt_sel == 2'b01 |-> tx_data_out);

  a_r1_all_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (patt_sel == 2'b00 && zero_sel) |-> !tx_data_out);

  a_r2_gen_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    gen[14:0] != '0 || gen[19:15] != '0);

  a_r3_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= 5'(LOOK));

  a_r5_window_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync) |-> ($past(rx_valid) && $past(wcnt) == '1));

  a_r7_frozen_out_of_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sync) && !$past(err_latch)) |-> $stable(err_count));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == '1 && !err_latch) |=> err_count == '1);

  a_r9_rise_captured: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> irq_status);

  a_r9_fall_captured: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync) && $past(irq_any_edge)) |-> irq_status);
endmodule

bind prbs_gen_mon prbs_gen_mon_chk #(.ERR_W(ERR_W), .WIN_LEN(WIN_LEN), .LOOK(LOOK)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_qrss(mode_qrss), .patt_sel(patt_sel),
  .zero_sel(zero_sel), .invert(invert), .tx_en(tx_en), .tx_data_out(tx_data_out),
  .rx_valid(rx_valid), .sync(sync), .wcnt(wcnt), .gen(gen),
  .err_latch(err_latch), .err_count(err_count),
  .irq_any_edge(irq_any_edge), .irq_status(irq_status)
);

// File: tb/sim_prbs_gen_mon.sv
module sim_prbs_gen_mon;
  localparam int          EW   = 8;
  localparam logic [19:0] SD   = 20'h00001;
  localparam int          N    = 4096;
  localparam time         TCLK = 20ns;

  logic clk = 0, rst_n = 0;
  logic mode_qrss = 0, zero_sel = 0, invert = 0, tx_en = 0, tx_data_in = 0;
  logic [1:0] patt_sel = 0;
  logic rx_valid = 0, rx_data = 0, err_latch = 0;
  logic irq_any_edge = 0, irq_en = 0, irq_clr = 0;
  logic tx_data_out, sync, irq_status, irq;
  logic [EW-1:0] err_count, err_snap;

  int nchk = 0, nfail = 0;
  logic le1 [N];
  logic lt1 [N];

  always #(TCLK/2) clk = ~clk;

  prbs_gen_mon #(.ERR_W(EW), .SEED(SD)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_qrss(mode_qrss), .patt_sel(patt_sel),
    .zero_sel(zero_sel), .invert(invert), .tx_en(tx_en), .tx_data_in(tx_data_in),
    .tx_data_out(tx_data_out), .rx_valid(rx_valid), .rx_data(rx_data), .sync(sync),
    .err_latch(err_latch), .err_count(err_count), .err_snap(err_snap),
    .irq_any_edge(irq_any_edge), .irq_en(irq_en), .irq_clr(irq_clr),
    .irq_status(irq_status), .irq(irq));

  // fields: patt_sel[1:0], zero_sel, tx_data_in, expected
  localparam logic [4:0] TV [8] = '{
    5'b00_0_0_0, 5'b00_0_1_1, 5'b00_1_1_0, 5'b00_1_0_0,
    5'b01_0_0_1, 5'b01_1_0_1, 5'b11_0_1_1, 5'b11_1_0_0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; rx_valid = 0; tx_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_bit(input int i, input logic flip);
    @(negedge clk);
    rx_valid = 1;
    rx_data  = le1[i] ^ flip ^ invert;
  endtask

  task automatic idle();
    @(negedge clk); rx_valid = 0; err_latch = 0; irq_clr = 0; #2;
  endtask

  task automatic send_block(input int first, input int nerr, input int at);
    for (int i = first; i < first + 64; i++)
      send_bit(i, (i >= first + at) && (i < first + at + nerr));
    idle();
  endtask

  initial begin
    logic raw1 [N+LOOKB];
    logic raw2 [N+LOOKB];
    logic [19:0] h;
    int zr, zmax;
    h = SD;
    for (int i = 0; i < N + LOOKB; i++) begin raw1[i] = h[14] ^ h[13]; h = {h[18:0], raw1[i]}; end
    h = SD;
    for (int i = 0; i < N + LOOKB; i++) begin raw2[i] = h[19] ^ h[16]; h = {h[18:0], raw2[i]}; end
    for (int i = 0; i < N; i++) begin
      logic any;
      any = 0;
      for (int k = 1; k <= 14; k++) any = any | raw2[i+k];
      le1[i] = raw1[i];
      lt1[i] = raw2[i] | !any;
    end

    do_reset();
    #2;
    check("R10 sync", sync, 0);
    check("R10 err_count", err_count, 0);
    check("R10 err_snap", err_snap, 0);
    check("R10 irq_status", irq_status, 0);

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {patt_sel, zero_sel, tx_data_in} = TV[v][4:1];
      #2 check("R1 select", tx_data_out, TV[v][0]);
    end

    do_reset();
    mode_qrss = 0; patt_sel = 2'b10; zero_sel = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); tx_en = 1; #2;
      check("R2 15-stage bit", tx_data_out, le1[i]);
    end
    @(negedge clk); tx_en = 0;

    do_reset();
    mode_qrss = 1; zr = 0; zmax = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); tx_en = 1; #2;
      check("R3 20-stage bit", tx_data_out, lt1[i]);
      zr = tx_data_out ? 0 : zr + 1;
      if (zr > zmax) zmax = zr;
    end
    check("R3 longest zero run", zmax, 14);

    do_reset();
    invert = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); tx_en = 1; #2;
      check("R4 inverted bit", tx_data_out, !lt1[i]);
    end
    @(negedge clk); tx_en = 0; invert = 0; mode_qrss = 0;

    do_reset();
    for (int i = 0; i < 63; i++) send_bit(i, 0);
    idle();
    check("R5 no change before block end", sync, 0);
    send_bit(63, 0);
    for (int i = 64; i < 128; i++) send_bit(i, 0);
    idle();
    check("R5 lock after clean block", sync, 1);
    check("R9 rise captured", irq_status, 1);
    check("R9 masked irq", irq, 0);
    irq_en = 1; #1;
    check("R9 enabled irq", irq, 1);
    check("R7 clean count", err_count, 0);
    @(negedge clk); irq_clr = 1; idle();
    check("R9 clear", irq_status, 0);

    send_block(128, 6, 2);
    check("R6 six errors keep lock", sync, 1);
    check("R7 counted while locked", err_count, 6);
    send_block(192, 7, 2);
    check("R5 seven errors drop lock", sync, 0);
    check("R7 count before drop", err_count, 13);
    check("R9 fall ignored", irq_status, 0);
    send_block(256, 10, 2);
    check("R6 reseed block stays out", sync, 0);
    check("R7 frozen out of lock", err_count, 13);
    irq_any_edge = 1;
    send_block(320, 0, 0);
    check("R6 relock after reseed", sync, 1);
    check("R9 rise any-edge", irq_status, 1);
    @(negedge clk); irq_clr = 1; idle();
    send_block(384, 7, 2);
    check("R9 fall captured", irq_status, 1);
    check("R7 count", err_count, 20);
    @(negedge clk); err_latch = 1; idle();
    check("R8 snapshot", err_snap, 20);
    check("R8 restart", err_count, 0);
    send_block(448, 0, 0);
    check("R5 lock again", sync, 1);
    for (int w = 0; w < 43; w++) send_block(512 + 64*w, 6, 2);
    check("R7 saturation", err_count, {EW{1'b1}});
    check("R6 lock under 6 per block", sync, 1);

    do_reset();
    invert = 1;
    for (int i = 0; i < 128; i++) send_bit(i, 0);
    idle();
    check("R4 inverted receive locks", sync, 1);
    check("R4 inverted receive clean", err_count, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  localparam int LOOKB = 14;

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule